// File: doc/BRIEF.md
# Excess-one carry-select adder

This block adds two unsigned operands of a parameterised width and a single carry-in bit. It has no clock and no state. It drives a sum of the same width and a carry-out. The operand is cut into groups that grow wider toward the most significant end, so the carry reaches each selection point at about the time the group's local result is ready.

The lowest group is an ordinary ripple adder fed by the external carry-in. Every higher group has only one ripple adder, which assumes an incoming carry of zero. That adder's carry-out and sum bits together form an (n+1)-bit word. An increment network derives the carry-in-one result from this word, using an inverter on bit zero and XORs against a growing AND chain on the higher bits. A two-way selector then forwards one of the two words, steered by the carry leaving the group below. The top bit of the forwarded word is the group's carry-out.

Legal widths are 8 and any multiple of 16. Each 16-bit section is cut at bits 2, 4, 7 and 11, and the pattern repeats section by section. The 8-bit variant is cut at bits 2 and 4.

Top module: `xs1_csel_adder`

## Requirements
- R1: For every pair of operands and either carry-in value, {cout, sum} equals the unsigned value a + b + cin, computed at width W+1.
- R2: Within each 16-bit section, group boundaries lie between bits 1|2, 3|4, 6|7 and 10|11. In the 8-bit variant they lie between bits 1|2 and 3|4. A carry generated below any of these boundaries reaches the sum bits above it.
- R3: The lowest group adds cin directly, so a = 0, b = 0, cin = 1 gives sum = 1 and cout = 0.
- R4: In every group above the lowest, the carry-in-one word equals the carry-in-zero word (group carry-out above n sum bits) plus one, modulo 2^(n+1). All-ones plus zero with cin = 1 therefore gives sum = 0 and cout = 1.
- R5: Each group's sum bits equal the carry-in-zero sum when the carry entering the group is 0, and the carry-in-one sum when that carry is 1.
- R6: The carry leaving each group is the top bit of the word that group selected, and it is the selection input of the next group.
- R7: With W = 8, every one of the 2^17 input combinations gives the result of R1.
- R8: All-ones plus one gives sum = 0 and cout = 1. All-ones plus all-ones with cin = 1 gives sum = all-ones and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First unsigned operand |
| b | input | W | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of a + b + cin |
| cout | output | 1 | Carry out of the top group |

## Verification
The checker evaluates its properties only when every operand and carry-in bit is known, because an unknown bit makes the ripple and increment results meaningless. The bench drives a, b and cin to defined values from time zero and never releases them to an unknown state. The per-group properties also assume the group map is the one described above: 8 bits, or a multiple of 16 bits. The bench instantiates only those two widths.

// File: rtl/xs1_pkg.sv
// Group map shared by the adder and its checker.
// Assumes W is 8 or a multiple of 16.
package xs1_pkg;

    // Number of carry-select groups for a given width.
    function automatic int grp_count(input int w);
        return (w == 8) ? 3 : (w / 16) * 5;
    endfunction

    // Lowest bit position of group g.
    function automatic int grp_lsb(input int w, input int g);
        int off;
        if (w == 8) return 2 * g;
        case (g % 5)
            0:       off = 0;
            1:       off = 2;
            2:       off = 4;
            3:       off = 7;
            default: off = 11;
        endcase
        return (g / 5) * 16 + off;
    endfunction

    // Number of bits in group g.
    function automatic int grp_width(input int w, input int g);
        if (g == grp_count(w) - 1) return w - grp_lsb(w, g);
        return grp_lsb(w, g + 1) - grp_lsb(w, g);
    endfunction

endpackage

// File: rtl/xs1_rca_cin.sv
// Ripple-carry adder with an external carry input; full adders at every bit.
// Assumes N >= 1.
module xs1_rca_cin #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         ci,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N:0] c;

    assign c[0] = ci;

    // One full adder per bit, carry rippling upward.
    for (genvar i = 0; i < N; i++) begin : g_fa
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign co = c[N];
endmodule

// File: rtl/xs1_rca_zero.sv
// Ripple-carry adder that assumes a zero carry input: a half adder at bit 0,
// full adders above it. Assumes N >= 2.
module xs1_rca_zero #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N:0] c;

    // Half adder at the lowest bit, full adders elsewhere.
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_ha
            assign s[i]   = a[i] ^ b[i];
            assign c[i+1] = a[i] & b[i];
        end else begin : g_fa
            assign s[i]   = a[i] ^ b[i] ^ c[i];
            assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
        end
    end

    assign c[0] = 1'b0;
    assign co   = c[N];
endmodule

// File: rtl/xs1_excess1.sv
// Increment network: dout = din + 1 modulo 2^N, built as an inverter on
// bit 0 and an XOR of each higher bit with the AND of all bits below it.
module xs1_excess1 #(
    parameter int N = 3
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] below_ones;

    assign below_ones[0] = 1'b1;

    // Running AND of the lower bits decides which bits toggle.
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign below_ones[i] = below_ones[i-1] & din[i-1];
    end

    assign dout = din ^ below_ones;
endmodule

// File: rtl/xs1_pick.sv
// Two-way word selector: q = d1 when sel is high, else d0.
module xs1_pick #(
    parameter int N = 3
) (
    input  logic         sel,
    input  logic [N-1:0] d0,
    input  logic [N-1:0] d1,
    output logic [N-1:0] q
);
    // Word-wide 2:1 selection.
    assign q = sel ? d1 : d0;
endmodule

// File: rtl/xs1_csel_adder.sv
// Carry-select adder with increment-based carry-in-one results.
// Purely combinational. Assumes W is 8 or a multiple of 16. The group map
// comes from xs1_pkg. Group-level nets are kept as flat vectors so that the
// bound checker can observe each stage.
module xs1_csel_adder #(
    parameter int W = 128
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NG = xs1_pkg::grp_count(W);

    logic [NG:0]   grp_cin;   // carry entering each group; [NG] leaves the top
    logic [W-1:0]  zsum;      // carry-in-zero sums
    logic [W-1:0]  isum;      // carry-in-one sums
    logic [NG-1:0] zco;       // carry-in-zero group carries
    logic [NG-1:0] ico;       // carry-in-one group carries

    assign grp_cin[0] = cin;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = xs1_pkg::grp_lsb(W, g);
        localparam int N  = xs1_pkg::grp_width(W, g);

        if (g == 0) begin : g_base
            // Lowest group: plain ripple adder fed by the external carry.
            xs1_rca_cin #(.N(N)) u_rca (
                .a  (a[LO +: N]),
                .b  (b[LO +: N]),
                .ci (grp_cin[g]),
                .s  (zsum[LO +: N]),
                .co (zco[g])
            );
            assign isum[LO +: N] = zsum[LO +: N];
            assign ico[g]        = zco[g];
            assign sum[LO +: N]  = zsum[LO +: N];
            assign grp_cin[g+1]  = zco[g];
        end else begin : g_sel
            // One zero-carry adder, an increment network, and a selector.
            xs1_rca_zero #(.N(N)) u_rca (
                .a  (a[LO +: N]),
                .b  (b[LO +: N]),
                .s  (zsum[LO +: N]),
                .co (zco[g])
            );
            xs1_excess1 #(.N(N + 1)) u_inc (
                .din  ({zco[g], zsum[LO +: N]}),
                .dout ({ico[g], isum[LO +: N]})
            );
            xs1_pick #(.N(N + 1)) u_pick (
                .sel (grp_cin[g]),
                .d0  ({zco[g], zsum[LO +: N]}),
                .d1  ({ico[g], isum[LO +: N]}),
                .q   ({grp_cin[g+1], sum[LO +: N]})
            );
        end
    end

    assign cout = grp_cin[NG];
endmodule

// File: rtl/xs1_csel_chk.sv
// Property checker for xs1_csel_adder. The block has no clock, so the
// checks are immediate assertions that settle with the combinational logic.
// They are skipped while any input or output bit is unknown.
module xs1_csel_chk #(
    parameter int W = 128
) (
    input logic [W-1:0]                      a,
    input logic [W-1:0]                      b,
    input logic                              cin,
    input logic [W-1:0]                      sum,
    input logic                              cout,
    input logic [xs1_pkg::grp_count(W):0]    grp_cin,
    input logic [W-1:0]                      zsum,
    input logic [W-1:0]                      isum,
    input logic [xs1_pkg::grp_count(W)-1:0]  zco,
    input logic [xs1_pkg::grp_count(W)-1:0]  ico
);
    localparam int NG = xs1_pkg::grp_count(W);

    // Re-evaluate every property whenever the block settles.
    always_comb begin
        logic [W:0] msk;
        logic [W:0] raw_w;
        logic [W:0] inc_w;
        int         lo;
        int         n;
        if (!$isunknown({a, b, cin, sum, cout, grp_cin, zsum, isum, zco, ico})) begin
            // R1
            total_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
                else $error("total sum mismatch");
            for (int g = 0; g < NG; g++) begin
                lo    = xs1_pkg::grp_lsb(W, g);
                n     = xs1_pkg::grp_width(W, g);
                msk   = ((W+1)'(1) << n) - (W+1)'(1);
                raw_w = (((W+1)'(zsum) >> lo) & msk) | ((W+1)'(zco[g]) << n);
                inc_w = (((W+1)'(isum) >> lo) & msk) | ((W+1)'(ico[g]) << n);
                if (g > 0) begin
                    // R4
                    incr_word_chk: assert (inc_w == ((raw_w + (W+1)'(1)) & ((msk << 1) | (W+1)'(1))))
                        else $error("increment word wrong in group %0d", g);
                end
                // R5
                sum_pick_chk: assert ((((W+1)'(sum) >> lo) & msk) == (grp_cin[g] ? (inc_w & msk) : (raw_w & msk)))
                    else $error("sum selection wrong in group %0d", g);
                // R6
                carry_link_chk: assert (grp_cin[g+1] == (grp_cin[g] ? ico[g] : zco[g]))
                    else $error("carry link wrong after group %0d", g);
            end
        end
    end
endmodule

bind xs1_csel_adder xs1_csel_chk #(.W(W)) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .grp_cin (grp_cin),
    .zsum    (zsum),
    .isum    (isum),
    .zco     (zco),
    .ico     (ico)
);

// File: tb/xs1_csel_adder_tb.sv
// Self-checking bench: a vector table at 128 bits, random vectors, and an
// exhaustive sweep of the 8-bit variant.
module xs1_csel_adder_tb;
    localparam int WB = 128;

    typedef struct packed {
        logic [WB-1:0] a;
        logic [WB-1:0] b;
        logic          ci;
        logic [WB:0]   exp;
    } vec_t;

    localparam logic [WB-1:0] ONES = {WB{1'b1}};
    localparam logic [WB-1:0] TOPB = {1'b1, {(WB-1){1'b0}}};

    localparam vec_t VECS [9] = '{
        '{a: '0,            b: '0,            ci: 1'b0, exp: '0},                          // R1 zero
        '{a: ONES,          b: WB'(1),        ci: 1'b0, exp: {1'b1, {WB{1'b0}}}},          // R8 ones+1
        '{a: ONES,          b: ONES,          ci: 1'b1, exp: {1'b1, ONES}},                // R8 max+max+1
        '{a: ONES,          b: '0,            ci: 1'b1, exp: {1'b1, {WB{1'b0}}}},          // R4 full chain
        '{a: '0,            b: '0,            ci: 1'b1, exp: (WB+1)'(1)},                  // R3 cin only
        '{a: WB'(3),        b: WB'(1),        ci: 1'b0, exp: (WB+1)'(4)},                  // R2 cross 1|2
        '{a: WB'(16'h07FF), b: WB'(1),        ci: 1'b0, exp: (WB+1)'(17'h00800)},          // R2 cross 10|11
        '{a: WB'(16'hFFFF), b: WB'(1),        ci: 1'b0, exp: (WB+1)'(17'h10000)},          // R2 cross section
        '{a: TOPB,          b: TOPB,          ci: 1'b0, exp: {1'b1, {WB{1'b0}}}}           // R1 top carry
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [WB-1:0] a = '0;
    logic [WB-1:0] b = '0;
    logic          cin = 1'b0;
    logic [WB-1:0] sum;
    logic          cout;

    logic [7:0] a8 = '0;
    logic [7:0] b8 = '0;
    logic       cin8 = 1'b0;
    logic [7:0] sum8;
    logic       cout8;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    xs1_csel_adder #(.W(WB)) u_dut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    xs1_csel_adder #(.W(8)) u_dut_w8 (
        .a(a8), .b(b8), .cin(cin8), .sum(sum8), .cout(cout8)
    );

    task automatic chk(input string tag, input logic [WB:0] got, input logic [WB:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after reset", {cout, sum}, '0);

        // Table of directed vectors.
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            a = VECS[i].a; b = VECS[i].b; cin = VECS[i].ci;
            #2;
            chk($sformatf("R1 table entry %0d", i), {cout, sum}, VECS[i].exp);
        end

        // R2: a carry generated below each boundary inside a section.
        for (int k = 0; k < 8; k++) begin
            int bnd;
            bnd = (k % 4 == 0) ? 2 : (k % 4 == 1) ? 4 : (k % 4 == 2) ? 7 : 11;
            bnd = bnd + (k / 4) * 16 * 3;
            @(negedge clk);
            a = (WB'(1) << bnd) - WB'(1); b = '0; cin = 1'b1;
            #2;
            chk($sformatf("R2 boundary at %0d", bnd), {cout, sum}, (WB+1)'(1) << bnd);
        end

        // R1: random operands against the behavioural sum.
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            if (i % 4 == 1) b = ~a;
            cin = 1'(($urandom));
            #2;
            chk("R1 random", {cout, sum}, {1'b0, a} + {1'b0, b} + {{WB{1'b0}}, cin});
        end

        // R7: exhaustive sweep of the 8-bit variant.
        @(negedge clk);
        for (int i = 0; i < (1 << 17); i++) begin
            a8 = i[7:0]; b8 = i[15:8]; cin8 = i[16];
            #1;
            chk("R7 exhaustive 8-bit", (WB+1)'({cout8, sum8}),
                (WB+1)'({1'b0, i[7:0]} + {1'b0, i[15:8]} + {8'b0, i[16]}));
            #1;
        end

        done = 1'b1;
        finish_run();
    end
endmodule